// File: doc/BRIEF.md
# Message Recovery Subtract-and-Encode Unit

This unit finishes a lattice decryption step. Two polynomials with 256 coefficients each, `v` and `p`, sit in two separate single-port memories. Every coefficient is already reduced into the range 0 to 3328. After a `start` pulse, the unit streams both memories at the same index. It forms `w = v - p mod 3329` and writes each `w` back over the matching `p` entry, so no third buffer is needed.

A second pass then reads `w` back from the `p` memory, one coefficient every two cycles. It reduces each value to one bit with a fixed-window threshold and sets that bit in a 256-bit message register. The register reads as 32 bytes packed least-significant bit first. `done` rises once the last bit is placed and stays high until the next `start`.

Both memories are modelled as synchronous reads: the data for an address presented in one cycle appears in the next cycle. The multiply-accumulate and inverse transform that produce `p` are handled elsewhere.

Top module: `msg_recover`

## Requirements
- R1: Each written value equals `v - p` when `v >= p`, and `v - p + 3329` when `v < p`, for inputs in 0..3328.
- R2: During the subtract pass both read addresses carry the same index. Index k is presented in the k-th cycle after `start` is sampled, for k = 0..255 in ascending order.
- R3: The result for index k appears on `p_wr_en`/`p_wr_addr`/`p_wr_data` in the cycle after index k was read, with `p_wr_addr = k`, overwriting the p entry in place. Each run makes exactly 256 writes.
- R4: A coefficient compresses to 1 exactly when 832 < w <= 2496, and to 0 otherwise.
- R5: Bit n of `msg` (bit 0 = LSB) holds the compressed bit of coefficient n, so byte j holds coefficients 8j..8j+7 with the lowest index in its bit 0.
- R6: The encode pass begins only after the last subtract write. It presents `p_rd_addr` = n for two consecutive cycles for n = 0..255, starting 257 cycles after `start` is sampled, and makes no writes.
- R7: After reset `msg` is all zero and `done` is low. `done` rises 769 cycles after `start` is sampled and stays high until a new `start`.
- R8: A `start` that arrives while a run is in progress is ignored. The run's addresses, writes and timing are unchanged.
- R9: A `start` given while `done` is high begins a fresh run with the same timing as a run started from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle or done) |
| v_rd_addr | output | 8 | Read address into the v memory |
| v_rd_data | input | 12 | v memory read data, one cycle after address |
| p_rd_addr | output | 8 | Read address into the p/w memory |
| p_rd_data | input | 12 | p/w memory read data, one cycle after address |
| p_wr_en | output | 1 | Write strobe into the p/w memory |
| p_wr_addr | output | 8 | Write address into the p/w memory |
| p_wr_data | output | 12 | Value written (w = v - p mod 3329) |
| msg | output | 256 | Recovered message, bit n from coefficient n |
| done | output | 1 | Run complete; held until next start |

## Verification
The bench targets the borrow path: pairs with `v < p`, `v = p` and the extremes 0 and 3328. A missing or doubled correction would write values of 3329 or more, or values that are wrong by 3329.

It places `w` exactly on 831, 832, 833, 2495, 2496 and 2497. An off-by-one or swapped comparison in the compressor flips one of those message bits.

It checks the read and write index on every cycle of a run. A write pipeline that is one stage too short or too long then shows up as a shifted address or a stale data word. An encode pass that starts before the final write reads a stale `p` value at index 255.

A stray `start` mid-run and a restart straight from `done` catch a controller that re-arms at the wrong moment.

// File: rtl/msgrec_pkg.sv
// Package: shared state encoding for the message recovery unit.
// Assumes nothing beyond being compiled before the modules that import it.
package msgrec_pkg;

    typedef enum logic [2:0] {
        MR_IDLE  = 3'd0,
        MR_SUB   = 3'd1,
        MR_DRAIN = 3'd2,
        MR_ENC   = 3'd3,
        MR_DONE  = 3'd4
    } mr_state_e;

endpackage

// File: rtl/msgrec_modsub.sv
// Module: msgrec_modsub
// Combinational modular difference w = a - b mod MODQ. The subtract is one bit
// wider than the operands; a set top bit means a borrow, and MODQ is added back.
// Assumes both operands are already reduced into 0..MODQ-1, so one correction
// is enough and no further reduction follows.
module msgrec_modsub #(
    parameter int CW   = 12,
    parameter int MODQ = 3329
) (
    input  logic [CW-1:0] a_i,
    input  logic [CW-1:0] b_i,
    output logic [CW-1:0] w_o
);

    logic [CW:0]   diff;
    logic [CW-1:0] low;

    // Wide difference; the top bit flags a borrow.
    always_comb begin
        diff = {1'b0, a_i} - {1'b0, b_i};
        low  = diff[CW-1:0];
    end

    // Borrow correction: add the modulus back when the difference went negative.
    always_comb begin
        if (diff[CW]) w_o = low + CW'(MODQ);
        else          w_o = low;
    end

endmodule

// File: rtl/msgrec_compress1.sv
// Module: msgrec_compress1
// One-bit compressor: the output is 1 when the coefficient lies above a quarter
// of the modulus and at or below three quarters of it, and 0 otherwise.
// Assumes the input is reduced into 0..MODQ-1.
module msgrec_compress1 #(
    parameter int CW   = 12,
    parameter int MODQ = 3329
) (
    input  logic [CW-1:0] x_i,
    output logic          bit_o
);

    localparam int LO_BOUND = MODQ / 4;
    localparam int HI_BOUND = (3 * MODQ) / 4;

    // Window test against the fixed bounds.
    always_comb begin
        bit_o = (x_i > CW'(LO_BOUND)) && (x_i <= CW'(HI_BOUND));
    end

endmodule

// File: rtl/msgrec_sub_pass.sv
// Module: msgrec_sub_pass
// Index sequencer for the subtract pass. It presents one index per cycle to both
// memories. Because read data returns one cycle later, it registers a valid flag
// and the index, so the write lands in the following cycle.
// Assumes run is held for exactly N_COEF cycles per pass by the controller.
module msgrec_sub_pass #(
    parameter int N_COEF = 256,
    parameter int AW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          run_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          last_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o
);

    logic [AW-1:0] idx_q;
    logic          vld_q;
    logic [AW-1:0] widx_q;

    // Read index: cleared on arm, advanced once per running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (arm_i)      idx_q <= '0;
        else if (run_i) begin
            if (idx_q == AW'(N_COEF - 1)) idx_q <= '0;
            else                          idx_q <= idx_q + 1'b1;
        end
    end

    // Write-side pipeline: valid and index trail the read by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            widx_q <= '0;
        end else begin
            vld_q  <= run_i;
            widx_q <= idx_q;
        end
    end

    assign rd_addr_o = idx_q;
    assign last_o    = run_i && (idx_q == AW'(N_COEF - 1));
    assign wr_en_o   = vld_q;
    assign wr_addr_o = widx_q;

endmodule

// File: rtl/msgrec_enc_pass.sv
// Module: msgrec_enc_pass
// Encode pass: two cycles per coefficient. In the first it presents the address;
// in the second it takes the returned word, compresses it and sets its message bit.
// Assumes the memory returns data one cycle after the address, and that
// arm is asserted the cycle before run begins.
module msgrec_enc_pass #(
    parameter int N_COEF = 256,
    parameter int AW     = 8,
    parameter int CW     = 12,
    parameter int MODQ   = 3329
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              run_i,
    input  logic [CW-1:0]     rd_data_i,
    output logic [AW-1:0]     rd_addr_o,
    output logic              fin_o,
    output logic [N_COEF-1:0] msg_o
);

    logic [AW-1:0]     idx_q;
    logic              ph_q;
    logic              cbit;
    logic [N_COEF-1:0] msg_q;

    msgrec_compress1 #(.CW(CW), .MODQ(MODQ)) u_cmp (
        .x_i   (rd_data_i),
        .bit_o (cbit)
    );

    // Index and phase: cleared when armed, stepped while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ph_q  <= 1'b0;
        end else if (arm_i) begin
            idx_q <= '0;
            ph_q  <= 1'b0;
        end else if (run_i) begin
            ph_q <= ~ph_q;
            if (ph_q) idx_q <= idx_q + 1'b1;
        end
    end

    // Message register: cleared on reset, one bit set per capture phase.
    always_ff @(posedge clk) begin
        if (!rst_n)              msg_q <= '0;
        else if (run_i && ph_q)  msg_q[idx_q] <= cbit;
    end

    assign rd_addr_o = idx_q;
    assign fin_o     = run_i && ph_q && (idx_q == AW'(N_COEF - 1));
    assign msg_o     = msg_q;

    // R5: the message only changes in a capture cycle.
    a_r5_msg_only_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_i && ph_q) |=> $stable(msg_o));

    // R6: the address is held across the two cycles of a coefficient.
    a_r6_addr_held_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ph_q && !arm_i) |=> (rd_addr_o == $past(rd_addr_o)));

endmodule

// File: rtl/msg_recover.sv
// Module: msg_recover (top)
// Computes w = v - p mod MODQ over N_COEF coefficients and writes w in place over p.
// It then compresses each w to one bit and packs the bits into msg, LSB first.
// Assumes synchronous one-cycle-latency memories and inputs reduced into 0..MODQ-1.
module msg_recover
    import msgrec_pkg::*;
#(
    parameter int N_COEF = 256,
    parameter int MODQ   = 3329,
    parameter int CW     = 12,
    localparam int AW    = $clog2(N_COEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [AW-1:0]     v_rd_addr,
    input  logic [CW-1:0]     v_rd_data,
    output logic [AW-1:0]     p_rd_addr,
    input  logic [CW-1:0]     p_rd_data,
    output logic              p_wr_en,
    output logic [AW-1:0]     p_wr_addr,
    output logic [CW-1:0]     p_wr_data,
    output logic [N_COEF-1:0] msg,
    output logic              done
);

    mr_state_e     st_q, st_d;
    logic          sub_arm, sub_run, sub_last;
    logic          enc_arm, enc_run, enc_fin;
    logic [AW-1:0] sub_addr, enc_addr;

    // Pass sequencing: idle/done -> subtract -> drain -> encode -> done.
    always_comb begin
        st_d = st_q;
        case (st_q)
            MR_IDLE:  if (start)    st_d = MR_SUB;
            MR_SUB:   if (sub_last) st_d = MR_DRAIN;
            MR_DRAIN:               st_d = MR_ENC;
            MR_ENC:   if (enc_fin)  st_d = MR_DONE;
            MR_DONE:  if (start)    st_d = MR_SUB;
            default:                st_d = MR_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MR_IDLE;
        else        st_q <= st_d;
    end

    assign sub_arm = start && ((st_q == MR_IDLE) || (st_q == MR_DONE));
    assign sub_run = (st_q == MR_SUB);
    assign enc_arm = (st_q == MR_DRAIN);
    assign enc_run = (st_q == MR_ENC);

    msgrec_sub_pass #(.N_COEF(N_COEF), .AW(AW)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (sub_arm),
        .run_i     (sub_run),
        .rd_addr_o (sub_addr),
        .last_o    (sub_last),
        .wr_en_o   (p_wr_en),
        .wr_addr_o (p_wr_addr)
    );

    msgrec_modsub #(.CW(CW), .MODQ(MODQ)) u_diff (
        .a_i (v_rd_data),
        .b_i (p_rd_data),
        .w_o (p_wr_data)
    );

    msgrec_enc_pass #(.N_COEF(N_COEF), .AW(AW), .CW(CW), .MODQ(MODQ)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (enc_arm),
        .run_i     (enc_run),
        .rd_data_i (p_rd_data),
        .rd_addr_o (enc_addr),
        .fin_o     (enc_fin),
        .msg_o     (msg)
    );

    // Address steering: the encode pass owns the p read port while it runs.
    always_comb begin
        v_rd_addr = sub_addr;
        p_rd_addr = enc_run ? enc_addr : sub_addr;
    end

    assign done = (st_q == MR_DONE);

    // R1: every written value is reduced below the modulus.
    a_r1_wr_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        p_wr_en |-> (p_wr_data < CW'(MODQ)));

    // R3: back-to-back writes walk the p memory in ascending order.
    a_r3_wr_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wr_en && $past(p_wr_en)) |-> (p_wr_addr == $past(p_wr_addr) + 1'b1));

    // R6: no write overlaps the encode pass.
    a_r6_no_wr_in_enc: assert property (@(posedge clk) disable iff (!rst_n)
        enc_run |-> !p_wr_en);

    // R7: done holds until a new start arrives.
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R8: start during the subtract pass does not disturb it.
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_run && start && !sub_last) |=> (st_q == MR_SUB));

endmodule

// File: tb/sim_msg_recover.sv
module sim_msg_recover;

    localparam int Q = 3329;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   v_rd_addr, p_rd_addr, p_wr_addr;
    logic [11:0]  v_rd_data, p_rd_data, p_wr_data;
    logic         p_wr_en, done;
    logic [255:0] msg;

    logic [11:0] v_mem [256];
    logic [11:0] p_mem [256];
    int          ov [256];
    int          op [256];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    msg_recover u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .v_rd_addr(v_rd_addr), .v_rd_data(v_rd_data),
        .p_rd_addr(p_rd_addr), .p_rd_data(p_rd_data),
        .p_wr_en(p_wr_en), .p_wr_addr(p_wr_addr), .p_wr_data(p_wr_data),
        .msg(msg), .done(done)
    );

    // Memory models: one-cycle synchronous read, write at the edge.
    always @(posedge clk) begin
        v_rd_data <= v_mem[v_rd_addr];
        p_rd_data <= p_mem[p_rd_addr];
        if (p_wr_en) p_mem[p_wr_addr] <= p_wr_data;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic int expw(int v, int p);
        return (((v - p) % Q) + Q) % Q;
    endfunction

    function automatic int expbit(int w);
        return ((w > 832) && (w <= 2496)) ? 1 : 0;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(int pat);
        int bnd [8] = '{0, 831, 832, 833, 2495, 2496, 2497, 3328};
        for (int k = 0; k < 256; k++) begin
            int v = 0;
            int p = 0;
            case (pat)
                0: begin v = (k * 13) % Q; p = (k * 29 + 100) % Q; end
                1: begin  // R4 boundary window: w lands on each bound
                    int t;
                    p = (k * 11) % Q;
                    t = (k < 64) ? bnd[k % 8] : (k * 37) % Q;
                    v = (p + t) % Q;
                end
                2: begin v = 0; p = (k * 97) % Q; end        // R1 borrow everywhere
                default: begin                               // R1 extremes
                    if (k % 3 == 0)      begin v = Q - 1; p = 0;     end
                    else if (k % 3 == 1) begin v = 0;     p = Q - 1; end
                    else                 begin v = k;     p = k;     end
                end
            endcase
            ov[k] = v; op[k] = p;
            v_mem[k] = 12'(v); p_mem[k] = 12'(p);
        end
    endtask

    task automatic run(int pat, bit poke, bit from_done);
        load(pat);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);  // E0: start sampled
        for (int k = 0; k <= 772; k++) begin
            @(negedge clk);
            start = poke && (k == 100);  // R8 stray start mid-run
            if (k <= 255)
                chk(v_rd_addr == 8'(k) && p_rd_addr == 8'(k), "R2 read index",
                    {v_rd_addr, p_rd_addr}, k);
            if (k >= 1 && k <= 256) begin
                int e = expw(ov[k-1], op[k-1]);
                chk(p_wr_en && p_wr_addr == 8'(k-1), "R3 write slot", p_wr_addr, k - 1);
                chk(p_wr_data == 12'(e), "R1 difference", p_wr_data, e);
                if (from_done && k == 1)
                    chk(p_wr_en, "R9 restart from done", p_wr_en, 1);
            end else begin
                chk(!p_wr_en, "R6 no write outside subtract", p_wr_en, 0);
            end
            if (k >= 257 && k <= 768)
                chk(p_rd_addr == 8'((k - 257) / 2), "R6 encode address", p_rd_addr, (k - 257) / 2);
            if (k < 769) chk(!done, "R7 done early", done, 0);
            else         chk(done, "R7 done timing/hold", done, 1);
            if (poke && k >= 101 && k <= 256 && k == 101)
                chk(p_wr_addr == 8'(100), "R8 ignored start", p_wr_addr, 100);
        end
        for (int n = 0; n < 256; n++) begin
            int e = expw(ov[n], op[n]);
            chk(msg[n] == 1'(expbit(e)), (pat == 1) ? "R4 compress bound" : "R5 bit packing",
                msg[n], expbit(e));
            chk(p_mem[n] == 12'(e), "R3 in-place result", p_mem[n], e);
            chk(v_mem[n] == 12'(ov[n]), "R3 v untouched", v_mem[n], ov[n]);
        end
    endtask

    initial begin
        for (int k = 0; k < 256; k++) begin v_mem[k] = '0; p_mem[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(msg == '0, "R7 msg cleared", msg[63:0], 0);
        chk(!done, "R7 done low after reset", done, 0);
        chk(!p_wr_en, "R7 no write after reset", p_wr_en, 0);
        run(0, 1'b0, 1'b0);
        run(1, 1'b1, 1'b1);
        run(2, 1'b0, 1'b1);
        run(3, 1'b0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule